// File: doc/BRIEF.md
# Multiplexed Hex Display Scanner

This block drives a four-digit seven-segment display whose segment lines are shared by all digits, with each digit having its own common line. Only one digit is lit at a time. The block selects each digit in turn and holds it for about one millisecond, which is fast enough that a viewer sees all four digits lit together. While a digit is selected, the shared segment lines carry the glyph for that digit's hexadecimal nibble.

The value on the display comes from a built-in 16-bit counter. The counter steps slowly, by default about four times a second, so each number can be read. The least significant nibble goes to digit 0. Each digit has its own decimal-point input, and that input reaches the segment bus only while its digit is selected. The dwell time and the counter step period are given in microseconds. The number of clock cycles for each is derived from the clock frequency parameter.

Top module: `hex_scan_top`

## Requirements
- R1: `digitN` is active low, and exactly one of its bits is 0 in every cycle, including during reset.
- R2: Each digit stays selected for exactly DWELL cycles, where DWELL = (CLK_HZ/1,000,000)·DWELL_US.
- R3: The digits are scanned in the order 0, 1, 2, 3 and then back to 0. Digit i is selected when `digitN` bit i is 0.
- R4: `segOut` bit 7 is the decimal point and bits 6..0 are segments G..A, with 1 meaning lit. The glyphs for digits 0 to 9 are the hex codes 3F, 06, 5B, 4F, 66, 6D, 7D, 27, 7F and 6F.
- R5: The glyphs for nibble values 10 to 15 are 77 (A), 7C (b), 58 (c), 5E (d), 79 (E) and 71 (F).
- R6: While digit i is selected, `segOut[6:0]` shows counter bits 4i+3..4i. The segment bus and the digit selection change in the same cycle.
- R7: `segOut[7]` equals `dpIn[i]` for the selected digit i. The decimal-point bits of the other digits have no effect on the outputs.
- R8: The counter starts at zero and increases by one every TICK cycles, where TICK = (CLK_HZ/1,000,000)·TICK_US.
- R9: The counter wraps from FFFF to 0000.
- R10: A synchronous reset selects digit 0, restarts the dwell time and clears the counter. The dwell timer and the counter step timer both start again from the edge on which reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dpIn | input | 4 | Decimal-point request, one bit per digit |
| segOut | output | 8 | Segment bus: dp, G, F, E, D, C, B, A, active high |
| digitN | output | 4 | Digit commons, active low, one low at a time |

## Verification
A wrong digit index shows up at the ports in the same cycle. Either the low bit of `digitN` is in the wrong position, or `segOut` carries the glyph of a different nibble. The bench compares both outputs against a model on every cycle, so the error is caught in the first cycle it appears. An error in the dwell or tick timing shows up within one dwell period (four cycles in the bench) or one counter step period. A wrap error shows up on the cycle after the counter reaches FFFF, when every digit must read 0.

// File: rtl/hexscan_pkg.sv
package hexscan_pkg;

  // Strobes that the control side sends to the datapath
  typedef struct packed {
    logic scanAdvance;  // move to the next digit
    logic countStep;    // step the display counter
  } scanStrobe_t;

  // Maps a hex nibble to segments G..A, with 1 meaning lit
  function automatic logic [6:0] hexGlyph(input logic [3:0] nib);
    logic [6:0] g;
    case (nib)
      4'h0: g = 7'h3F;
      4'h1: g = 7'h06;
      4'h2: g = 7'h5B;
      4'h3: g = 7'h4F;
      4'h4: g = 7'h66;
      4'h5: g = 7'h6D;
      4'h6: g = 7'h7D;
      4'h7: g = 7'h27;
      4'h8: g = 7'h7F;
      4'h9: g = 7'h6F;
      4'hA: g = 7'h77;
      4'hB: g = 7'h7C;
      4'hC: g = 7'h58;
      4'hD: g = 7'h5E;
      4'hE: g = 7'h79;
      default: g = 7'h71;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/hexscan_timer.sv
module hexscan_timer #(
  parameter int unsigned PERIOD = 2
) (
  input  logic clk,
  input  logic rst,
  output logic pulse
);
  localparam int unsigned CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt;
  logic atLast;

  assign atLast = (cnt == LAST);
  assign pulse  = atLast;

  always_ff @(posedge clk) begin
    if (rst)         cnt <= '0;
    else if (atLast) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  // The count never goes past the last value of its period
  AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);  // R2

  // The timer starts again from zero when reset is released
  AST_TIMER_FRESH: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> cnt == '0);  // R10

endmodule

// File: rtl/hexscan_ctrl.sv
module hexscan_ctrl
  import hexscan_pkg::*;
#(
  parameter int unsigned DWELL_CYC = 50000,
  parameter int unsigned TICK_CYC  = 12500000
) (
  input  logic        clk,
  input  logic        rst,
  output scanStrobe_t strobe
);
  localparam int NUM_TIMERS = 2;
  localparam int unsigned PERIODS [NUM_TIMERS] = '{DWELL_CYC, TICK_CYC};

  logic [NUM_TIMERS-1:0] pulses;

  // Timer 0 sets the digit dwell, timer 1 sets the counter step
  for (genvar g = 0; g < NUM_TIMERS; g++) begin : gTimer
    hexscan_timer #(.PERIOD(PERIODS[g])) uTimer (
      .clk  (clk),
      .rst  (rst),
      .pulse(pulses[g])
    );
  end

  assign strobe.scanAdvance = pulses[0];
  assign strobe.countStep   = pulses[1];

endmodule

// File: rtl/hexscan_datapath.sv
module hexscan_datapath
  import hexscan_pkg::*;
#(
  parameter int DIGITS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  scanStrobe_t       strobe,
  input  logic [DIGITS-1:0] dpIn,
  output logic [7:0]        segOut,
  output logic [DIGITS-1:0] digitN
);
  localparam int IDX_W = (DIGITS > 1) ? $clog2(DIGITS) : 1;
  localparam int VAL_W = 4 * DIGITS;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DIGITS - 1);

  logic [IDX_W-1:0] digitIdx;
  logic [VAL_W-1:0] value;
  logic [3:0]       nibs [DIGITS];
  logic [3:0]       curNib;

  // Scan position and display counter. The outputs below are decoded from
  // these registers, so the segments and the select change on the same edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      digitIdx <= '0;
      value    <= '0;
    end else begin
      if (strobe.scanAdvance)
        digitIdx <= (digitIdx == LAST_IDX) ? '0 : digitIdx + 1'b1;
      if (strobe.countStep)
        value <= value + 1'b1;
    end
  end

  // One nibble per digit; digit 0 holds the least significant nibble
  for (genvar g = 0; g < DIGITS; g++) begin : gDigit
    assign nibs[g]   = value[g*4 +: 4];
    assign digitN[g] = (digitIdx != IDX_W'(g));
  end

  assign curNib = nibs[digitIdx];
  assign segOut = {dpIn[digitIdx], hexGlyph(curNib)};

  AST_ONE_DIGIT: assert property (@(posedge clk) disable iff (rst)
    $countones(~digitN) == 1);  // R1

  AST_DIGIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobe.scanAdvance |=> $stable(digitIdx));  // R2

  AST_SCAN_ORDER: assert property (@(posedge clk) disable iff (rst)
    strobe.scanAdvance |=>
      digitIdx == (($past(digitIdx) == LAST_IDX) ? '0 : $past(digitIdx) + 1'b1));  // R3

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    strobe.countStep |=> value == $past(value) + 1'b1);  // R8

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobe.countStep |=> $stable(value));  // R8

  AST_COUNT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (strobe.countStep && value == '1) |=> value == '0);  // R9

endmodule

// File: rtl/hex_scan_top.sv
module hex_scan_top
  import hexscan_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 50000000,
  parameter int unsigned DWELL_US = 1000,
  parameter int unsigned TICK_US  = 250000,
  parameter int          DIGITS   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIGITS-1:0] dpIn,
  output logic [7:0]        segOut,
  output logic [DIGITS-1:0] digitN
);
  localparam int unsigned CYC_PER_US = CLK_HZ / 1000000;
  localparam int unsigned DWELL_CYC  = CYC_PER_US * DWELL_US;
  localparam int unsigned TICK_CYC   = CYC_PER_US * TICK_US;

  scanStrobe_t strobe;

  hexscan_ctrl #(
    .DWELL_CYC(DWELL_CYC),
    .TICK_CYC (TICK_CYC)
  ) uCtrl (
    .clk   (clk),
    .rst   (rst),
    .strobe(strobe)
  );

  hexscan_datapath #(
    .DIGITS(DIGITS)
  ) uData (
    .clk   (clk),
    .rst   (rst),
    .strobe(strobe),
    .dpIn  (dpIn),
    .segOut(segOut),
    .digitN(digitN)
  );

endmodule

// File: tb/test_hex_scan_top.sv
module test_hex_scan_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int DWELL = 4;
  localparam int TICK_MAIN = 64;
  localparam int TICK_WRAP = 1;
  localparam int WATCHDOG_CYC = 150000;

  localparam logic [6:0] GLYPH [16] = '{
    7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h27,
    7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h58, 7'h5E, 7'h79, 7'h71};

  // Stimulus table: decimal-point patterns, each held for a number of cycles
  localparam int NVEC = 6;
  localparam logic [3:0] DP_VEC  [NVEC] = '{4'b0000, 4'b0001, 4'b0100, 4'b1000, 4'b1010, 4'b1111};
  localparam int         VEC_CYC [NVEC] = '{70, 40, 40, 40, 60, 40};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] dpIn = 4'b0000;
  logic [7:0] segMain, segWrap;
  logic [3:0] digMain, digWrap;
  int k = 0;
  int nChecks = 0;
  int nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) k <= rst ? 0 : k + 1;

  hex_scan_top #(.CLK_HZ(1000000), .DWELL_US(DWELL), .TICK_US(TICK_MAIN)) i_hex_scan_top (
    .clk(clk), .rst(rst), .dpIn(dpIn), .segOut(segMain), .digitN(digMain));

  hex_scan_top #(.CLK_HZ(1000000), .DWELL_US(DWELL), .TICK_US(TICK_WRAP)) i_hex_scan_top_wrap (
    .clk(clk), .rst(rst), .dpIn(dpIn), .segOut(segWrap), .digitN(digWrap));

  // Expected {digitN, segOut} after kk clock edges out of reset
  function automatic logic [11:0] model(input int kk, input int tick, input logic [3:0] dpv);
    int idx;
    logic [15:0] v;
    logic [3:0] nib;
    idx = (kk / DWELL) % 4;
    v = 16'(kk / tick);
    nib = v[idx*4 +: 4];
    return {~(4'b0001 << idx), dpv[idx], GLYPH[nib]};
  endfunction

  function automatic logic [3:0] modelNib(input int kk, input int tick);
    logic [15:0] v;
    v = 16'(kk / tick);
    return v[((kk / DWELL) % 4)*4 +: 4];
  endfunction

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s k=%0d actual=%h expected=%h", tag, k, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    // R10 and R1: state while reset is held
    repeat (2) @(negedge clk);
    check("R10 R1 reset main", {digMain, segMain}, {4'b1110, 1'b0, 7'h3F});
    check("R10 R1 reset wrap", {digWrap, segWrap}, {4'b1110, 1'b0, 7'h3F});
    rst = 1'b0;

    // Walk the table; compare against the model on every cycle (R1 R2 R3 R6 R7 R8)
    for (int vi = 0; vi < NVEC; vi++) begin
      dpIn = DP_VEC[vi];
      repeat (VEC_CYC[vi]) begin
        @(negedge clk);
        check("R1 R2 R3 R6 R7 R8 scan", {digMain, segMain}, model(k, TICK_MAIN, dpIn));
      end
    end

    // R2: first dwell boundary after reset, checked on its own
    dpIn = 4'b0000;
    rst = 1'b1;
    @(negedge clk);
    check("R10 mid-run reset main", {digMain, segMain}, {4'b1110, 1'b0, 7'h3F});
    check("R10 mid-run reset wrap", {digWrap, segWrap}, {4'b1110, 1'b0, 7'h3F});
    rst = 1'b0;
    repeat (DWELL - 1) @(negedge clk);
    check("R2 last dwell cycle digit0", {8'h00, digMain}, {8'h00, 4'b1110});
    @(negedge clk);
    check("R2 R3 advance to digit1", {8'h00, digMain}, {8'h00, 4'b1101});

    // R4 R5 R9: fast counter walks every glyph and wraps
    while (k < 65540) begin
      @(negedge clk);
      if (modelNib(k, TICK_WRAP) < 4'd10)
        check("R4 R9 glyph wrap", {digWrap, segWrap}, model(k, TICK_WRAP, dpIn));
      else
        check("R5 R9 glyph wrap", {digWrap, segWrap}, model(k, TICK_WRAP, dpIn));
      if (k == 65535)
        check("R9 at FFFF", {digWrap, segWrap}, {4'b0111, 1'b0, 7'h71});
      if (k == 65536)
        check("R9 wrapped to 0000", {digWrap, segWrap}, {4'b1110, 1'b0, 7'h3F});
    end

    summary();
  end
endmodule